// File: doc/BRIEF.md
# Bus-Idle Sleep Mode Controller

This block chooses between an active power mode and a sleep power mode by watching the two lines of a serial bus. The block holds a sleep-enable bit, which is cleared by reset. When that bit is set and both bus lines stay low without a break for a programmed number of system-clock ticks, the block takes this as pack disconnection and enters sleep. A high level on either line wakes it again. This can happen at any point and does not depend on any bus transaction being in progress.

The block also paces the measurement conversions. While active, it issues a conversion start pulse and a conversion done pulse on a fixed period. In sleep it issues neither, so the measurements and the charge accumulator stop. Every time measurement restarts, after reset or on wake, the period begins again from its start and the first result is marked as not valid.

The block also gates access to register groups. The configuration, current and accumulator groups can be reached in both modes. The voltage and temperature groups can be reached only in active mode.

Top module: `bus_idle_sleep_ctrl`

## Requirements
- R1: With the sleep-enable bit set and both lines driven low, `sleep_mode` rises exactly SYNC_STAGES+TIMEOUT_TICKS rising clock edges after the lines go low, and not earlier.
- R2: A high level on either line while the idle count runs restarts the count, even if it lasts only one clock. Sleep then follows exactly SYNC_STAGES+TIMEOUT_TICKS edges after both lines are low again.
- R3: The sleep-enable bit is 0 after reset and is written through `cfg_we`/`cfg_sleep_en`. While it is 0, the lines may stay low for any length of time and `sleep_mode` stays 0.
- R4: In sleep, a high level on either line clears `sleep_mode` exactly SYNC_STAGES+1 edges later. A single-clock pulse on one line is enough.
- R5: In sleep, `meas_en`, `conv_start` and `conv_done` are all 0.
- R6: While active, `conv_start` pulses once every CONV_TICKS cycles. `conv_done` pulses CONV_TICKS-1 cycles after each start.
- R7: When measurement restarts after reset or on wake, `conv_start` is high in the first active cycle. The first `conv_done` then comes with `conv_valid`=0, and later ones come with `conv_valid`=1.
- R8: `reg_gnt` = `reg_req` AND the selected group is reachable. The `reg_sel` codes are 0 configuration, 1 current, 2 accumulator, 3 voltage and 4 temperature. Codes 0, 1 and 2 are reachable in both modes. Codes 3 and 4 are reachable only in active mode. Codes 5 to 7 are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Data line level, asynchronous |
| scl_in | input | 1 | Clock line level, asynchronous |
| cfg_we | input | 1 | Write strobe for the sleep-enable bit |
| cfg_sleep_en | input | 1 | New value of the sleep-enable bit |
| reg_req | input | 1 | Register access request |
| reg_sel | input | 3 | Register group code of the request |
| sleep_mode | output | 1 | 1 in sleep, 0 in active |
| meas_en | output | 1 | Measurement scheduling enabled |
| conv_start | output | 1 | Start pulse of a conversion cycle |
| conv_done | output | 1 | End pulse of a conversion cycle |
| conv_valid | output | 1 | Result of the ending conversion is valid |
| reg_gnt | output | 1 | Register access allowed |

## Verification
If the idle counter holds a wrong value, the cycle on which `sleep_mode` rises moves. The bench sees this on the exact edge it predicts, both for a clean low period and for one broken by a single-clock pulse. If the synchronizer or the mode state is wrong, the wake edge moves or wake never happens, and this shows SYNC_STAGES+1 clocks after a line rises. If the scheduler phase or the first-result flag is wrong, `conv_start` is missing in the first active cycle, or `conv_valid` has the wrong value at the first `conv_done`, which comes CONV_TICKS-1 cycles later.

// File: rtl/bis_pkg.sv
package bis_pkg;

    typedef enum logic {
        PM_ACTIVE = 1'b0,
        PM_SLEEP  = 1'b1
    } pwr_mode_e;

    localparam int NUM_LINES = 2;
    localparam int LINE_SDA  = 0;
    localparam int LINE_SCL  = 1;
    localparam int SEL_W     = 3;

    typedef enum logic [SEL_W-1:0] {
        GRP_CFG  = 3'd0,
        GRP_CUR  = 3'd1,
        GRP_ACC  = 3'd2,
        GRP_VOLT = 3'd3,
        GRP_TEMP = 3'd4
    } reg_grp_e;

    typedef struct packed {
        logic start;
        logic done;
        logic valid;
    } conv_evt_t;

    function automatic logic grp_reachable(logic [SEL_W-1:0] sel, pwr_mode_e mode);
        logic ok;
        case (sel)
            GRP_CFG, GRP_CUR, GRP_ACC: ok = 1'b1;
            GRP_VOLT, GRP_TEMP:        ok = (mode == PM_ACTIVE);
            default:                   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bis_line_sync.sv
module bis_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else if (STAGES == 1) begin
                    chain[0] <= raw[g];
                end else begin
                    chain <= {chain[STAGES-2:0], raw[g]};
                end
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bis_idle_timer.sv
module bis_idle_timer #(
    parameter int TIMEOUT_TICKS = 250_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [1:0] lines,
    output logic       expire
);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             idle;

    assign idle   = enable && (lines == 2'b00);
    assign expire = idle && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !idle) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bis_mode_fsm.sv
module bis_mode_fsm
    import bis_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      expire,
    input  logic      wake,
    output pwr_mode_e mode
);
    pwr_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            PM_ACTIVE: if (expire) mode_d = PM_SLEEP;
            PM_SLEEP:  if (wake)   mode_d = PM_ACTIVE;
            default:   mode_d = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_ACTIVE;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/bis_conv_sched.sv
module bis_conv_sched
    import bis_pkg::*;
#(
    parameter int CONV_TICKS = 1024
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output conv_evt_t evt
);
    localparam int PH_W = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CONV_TICKS - 1);

    logic [PH_W-1:0] phase_q;
    logic            first_q;
    logic            at_end;

    assign at_end = (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
            first_q <= 1'b1;
        end else begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
            if (at_end) first_q <= 1'b0;
        end
    end

    always_comb begin
        evt.start = run && (phase_q == '0);
        evt.done  = run && at_end;
        evt.valid = run && at_end && !first_q;
    end
endmodule

// File: rtl/bus_idle_sleep_ctrl.sv
module bus_idle_sleep_ctrl
    import bis_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int TIMEOUT_TICKS = 250_000_000,
    parameter int CONV_TICKS    = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             cfg_we,
    input  logic             cfg_sleep_en,
    input  logic             reg_req,
    input  logic [SEL_W-1:0] reg_sel,
    output logic             sleep_mode,
    output logic             meas_en,
    output logic             conv_start,
    output logic             conv_done,
    output logic             conv_valid,
    output logic             reg_gnt
);
    logic [NUM_LINES-1:0] lines_raw;
    logic [NUM_LINES-1:0] lines_s;
    logic                 sleep_en_q;
    logic                 expire;
    logic                 any_high;
    pwr_mode_e            mode;
    conv_evt_t            evt;

    assign lines_raw[LINE_SDA] = sda_in;
    assign lines_raw[LINE_SCL] = scl_in;
    assign any_high            = |lines_s;

    always_ff @(posedge clk) begin
        if (rst)         sleep_en_q <= 1'b0;
        else if (cfg_we) sleep_en_q <= cfg_sleep_en;
    end

    bis_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_LINES)) u_sync (
        .clk(clk), .rst(rst), .raw(lines_raw), .synced(lines_s)
    );

    bis_idle_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst(rst), .enable(sleep_en_q), .lines(lines_s), .expire(expire)
    );

    bis_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .expire(expire), .wake(any_high), .mode(mode)
    );

    assign sleep_mode = (mode == PM_SLEEP);
    assign meas_en    = (mode == PM_ACTIVE);

    bis_conv_sched #(.CONV_TICKS(CONV_TICKS)) u_sched (
        .clk(clk), .rst(rst), .run(meas_en), .evt(evt)
    );

    assign conv_start = evt.start;
    assign conv_done  = evt.done;
    assign conv_valid = evt.valid;
    assign reg_gnt    = reg_req && grp_reachable(reg_sel, mode);
endmodule

// File: rtl/bis_sleep_chk.sv
module bis_sleep_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lines_s,
    input logic       sleep_en_q,
    input logic       sleep_mode,
    input logic       meas_en,
    input logic       conv_start,
    input logic       conv_done,
    input logic       reg_req,
    input logic       reg_gnt
);
    AST_ENTRY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_mode) |-> ($past(sleep_en_q) && ($past(lines_s) == 2'b00))); // R1

    AST_WAKE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode && (lines_s != 2'b00)) |=> !sleep_mode); // R4

    AST_QUIET_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
        sleep_mode |-> !(conv_start || conv_done || meas_en)); // R5

    AST_RESTART_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(meas_en) |-> conv_start); // R7

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        reg_gnt |-> reg_req); // R8
endmodule

bind bus_idle_sleep_ctrl bis_sleep_chk u_chk (
    .clk(clk), .rst(rst), .lines_s(lines_s), .sleep_en_q(sleep_en_q),
    .sleep_mode(sleep_mode), .meas_en(meas_en), .conv_start(conv_start),
    .conv_done(conv_done), .reg_req(reg_req), .reg_gnt(reg_gnt)
);

// File: tb/bus_idle_sleep_ctrl_tb.sv
module bus_idle_sleep_ctrl_tb;
    localparam int SYNC = 2;
    localparam int TMO  = 40;
    localparam int CONV = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sda_in = 1'b1, scl_in = 1'b1;
    logic cfg_we = 1'b0, cfg_sleep_en = 1'b0;
    logic reg_req = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic sleep_mode, meas_en, conv_start, conv_done, conv_valid, reg_gnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_idle_sleep_ctrl #(.SYNC_STAGES(SYNC), .TIMEOUT_TICKS(TMO), .CONV_TICKS(CONV)) u_dut (
        .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
        .cfg_we(cfg_we), .cfg_sleep_en(cfg_sleep_en), .reg_req(reg_req), .reg_sel(reg_sel),
        .sleep_mode(sleep_mode), .meas_en(meas_en), .conv_start(conv_start),
        .conv_done(conv_done), .conv_valid(conv_valid), .reg_gnt(reg_gnt)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("[TB] FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_en(input logic v);
        cfg_we = 1'b1; cfg_sleep_en = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic check_gates(input logic asleep);
        reg_req = 1'b1;
        for (int s = 0; s < 8; s++) begin
            reg_sel = 3'(s);
            #1;
            check("R8", $sformatf("gnt sel %0d", s), int'(reg_gnt),
                  int'(s < 3 || (s < 5 && !asleep)));
        end
        reg_req = 1'b0;
        #1;
        check("R8", "gnt without req", int'(reg_gnt), 0);
    endtask

    task automatic t_reset_and_first_conv();
        check("R3", "sleep after reset", int'(sleep_mode), 0);
        check("R7", "start in first active cycle", int'(conv_start), 1);
        tick(CONV - 1);
        check("R6", "first done", int'(conv_done), 1);
        check("R7", "first result invalid", int'(conv_valid), 0);
        tick();
        check("R6", "start after one period", int'(conv_start), 1);
        tick(CONV - 1);
        check("R7", "second result valid", int'(conv_valid & conv_done), 1);
    endtask

    task automatic t_disabled_stays_active();
        int woke = 0;
        sda_in = 1'b0; scl_in = 1'b0;
        for (int i = 0; i < 3 * TMO; i++) begin
            tick();
            if (sleep_mode) woke++;
        end
        check("R3", "sleep cycles with enable 0", woke, 0);
        sda_in = 1'b1; scl_in = 1'b1;
        tick(SYNC + 2);
    endtask

    task automatic t_enter_sleep();
        sda_in = 1'b0; scl_in = 1'b0;
        tick(SYNC + TMO - 1);
        check("R1", "still active one edge early", int'(sleep_mode), 0);
        tick();
        check("R1", "sleep at exact edge", int'(sleep_mode), 1);
        check("R5", "meas_en in sleep", int'(meas_en), 0);
    endtask

    task automatic t_sleep_quiet();
        int ev = 0;
        for (int i = 0; i < 3 * CONV; i++) begin
            tick();
            if (conv_start || conv_done || meas_en) ev++;
        end
        check("R5", "conversion events in sleep", ev, 0);
        check_gates(1'b1);
    endtask

    task automatic t_wake_scl();
        scl_in = 1'b1;
        tick(SYNC);
        check("R4", "asleep before wake edge", int'(sleep_mode), 1);
        tick();
        check("R4", "awake after SYNC+1 edges", int'(sleep_mode), 0);
        check("R7", "start on wake", int'(conv_start), 1);
        tick(CONV - 1);
        check("R7", "first done after wake invalid", int'(conv_done & ~conv_valid), 1);
        tick(CONV);
        check("R7", "second done after wake valid", int'(conv_done & conv_valid), 1);
        check_gates(1'b0);
    endtask

    task automatic t_pulse_restarts();
        sda_in = 1'b1; scl_in = 1'b1;
        tick(SYNC + 2);
        sda_in = 1'b0; scl_in = 1'b0;
        tick(TMO / 2);
        sda_in = 1'b1;
        tick();
        sda_in = 1'b0;
        tick(SYNC + TMO - 1);
        check("R2", "active one edge before recount ends", int'(sleep_mode), 0);
        tick();
        check("R2", "sleep after full recount", int'(sleep_mode), 1);
    endtask

    task automatic t_glitch_wake();
        sda_in = 1'b1;
        tick();
        sda_in = 1'b0;
        tick(SYNC - 1);
        check("R4", "asleep before glitch wake", int'(sleep_mode), 1);
        tick();
        check("R4", "single-clock pulse wakes", int'(sleep_mode), 0);
        tick(5);
        check("R4", "stays awake after pulse", int'(sleep_mode), 0);
    endtask

    task automatic t_disable_again();
        sda_in = 1'b1; scl_in = 1'b1;
        tick(SYNC + 2);
        set_en(1'b0);
        t_disabled_stays_active();
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        t_reset_and_first_conv();
        check_gates(1'b0);
        t_disabled_stays_active();
        set_en(1'b1);
        tick(2);
        t_enter_sleep();
        t_sleep_quiet();
        t_wake_scl();
        t_pulse_restarts();
        t_glitch_wake();
        t_disable_again();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("[TB] FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule